// File: doc/BRIEF.md
# Receive Frame Status Queue

This block sits beside the receive path of a synchronous serial channel. It counts the bytes of each incoming frame. At every end of frame it stores that count, together with the frame's end-of-frame status bits, as one entry in a small first-in first-out queue. The receive side can therefore complete several short frames before the host has looked at any of them.

The host reads the oldest entry through a byte-wide, address-selected read port. Location 7 gives the two queue flags and the upper count bits. Location 6 gives the lower eight count bits. Location 1 gives the stored status bits, and a strobed read there retires the entry. The host reads 7, then 6, then 1. A level enable input selects queue mode. With the enable low, the queue is emptied, and locations 6 and 7 return the register images supplied on the image inputs instead of queue data.

Top module: `fsf_top`

## Requirements
- R1: The frame byte counter clears on `rx_sof`, and then counts each `rx_byte` strobe. A strobe in the same cycle as `rx_sof` counts as the first byte. The counter stops at 2^CNT_W-1.
- R2: With `fifo_en` high, an `rx_eof` pulse stores one entry {`rx_stat`, count}, where the count includes a byte strobe in the same cycle. The queue holds up to DEPTH entries and returns them oldest first.
- R3: With `fifo_en` high, location 6 (`rd_addr`=6) returns count bits 7..0 of the oldest entry. It returns 0 when the queue is empty.
- R4: With `fifo_en` high, location 7 returns the overflow flag in bit 7 and the data-available flag in bit 6. Bits 5..0 hold count bits CNT_W-1..8 of the oldest entry, zero-extended. These count bits read 0 when the queue is empty.
- R5: With `fifo_en` high and the queue not empty, location 1 returns `live1_img[7:STAT_W]` in the upper bits and the oldest entry's status in bits STAT_W-1..0. Otherwise location 1 returns `live1_img`.
- R6: A cycle with `rd_en` high and `rd_addr`=1, while the queue is enabled and not empty, removes the oldest entry. Strobed reads of locations 6 and 7 leave the queue unchanged.
- R7: A store into a full queue, with no removal in the same cycle, discards the new entry and sets the overflow flag. The flag stays set while `fifo_en` stays high.
- R8: While `fifo_en` is low, the queue is emptied, the overflow flag is cleared, and `rx_eof` stores nothing.
- R9: With `fifo_en` low, location 6 returns `img2` and location 7 returns `img3`. Locations 2 and 3 always return `img2` and `img3`. Locations 0, 4 and 5 return 0.
- R10: Data-available is 1 exactly when `fifo_en` is high and the queue holds at least one entry. After reset the queue is empty and the overflow flag is 0.
- R11: When a removal and a store fall in the same cycle on a full queue, both take effect and the overflow flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Queue mode enable (level) |
| rx_sof | input | 1 | Start-of-frame pulse |
| rx_byte | input | 1 | One received byte |
| rx_eof | input | 1 | End-of-frame pulse |
| rx_stat | input | STAT_W | End-of-frame status bits to store |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Host read location |
| live1_img | input | 8 | Current contents of the location-1 register |
| img2 | input | 8 | Image returned for location 2 / fallback 6 |
| img3 | input | 8 | Image returned for location 3 / fallback 7 |
| rd_data | output | 8 | Read data for `rd_addr` (combinational) |

## Verification
The bench builds the block with DEPTH=4, CNT_W=10 and STAT_W=4. A depth of four makes overflow, a full-queue removal coinciding with a store, and the drop of a fifth entry reachable within a few short frames. A 10-bit count saturates after 1023 bytes, which brings the count ceiling and the split of the count across locations 6 and 7 within a short run. A 4-bit status exercises the merge of live bits with stored bits at location 1, the variant that the default width of 8 does not use.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
   // host read locations; the numbering is what software decodes
   localparam logic [2:0] LOC_STAT   = 3'd1;
   localparam logic [2:0] LOC_IMG2   = 3'd2;
   localparam logic [2:0] LOC_IMG3   = 3'd3;
   localparam logic [2:0] LOC_CNT_LO = 3'd6;
   localparam logic [2:0] LOC_CNT_HI = 3'd7;

   typedef logic [7:0] byte_t;

   // width of the upper count field at LOC_CNT_HI
   localparam int HI_FIELD_W = 6;
endpackage

// File: rtl/fsf_bytecnt.sv
module fsf_bytecnt #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             byte_stb,
   output logic [CNT_W-1:0] cnt_nx,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] base;

   always_comb begin
      base   = sof ? '0 : cnt_q;
      cnt_nx = base;
      if (byte_stb && (base != CNT_MAX))
         cnt_nx = base + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nx;
   end
endmodule

// File: rtl/fsf_queue.sv
module fsf_queue #(
   parameter int DEPTH = 10,
   parameter int W     = 22,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int OW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  head,
   output logic [OW-1:0] occ,
   output logic          empty,
   output logic          dropped
);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr, rd_nx, wr_nx;
   logic          full, accept;

   assign full    = (occ == OW'(DEPTH));
   assign empty   = (occ == '0);
   assign accept  = push && (!full || pop);
   assign dropped = push && full && !pop;
   assign head    = mem[rd_ptr];

   generate
      if (POW2) begin : g_pow2
         assign rd_nx = rd_ptr + 1'b1;
         assign wr_nx = wr_ptr + 1'b1;
      end else begin : g_wrap
         assign rd_nx = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nx = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         occ    <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         occ    <= '0;
      end else begin
         if (accept) wr_ptr <= wr_nx;
         if (pop)    rd_ptr <= rd_nx;
         if (accept && !pop)      occ <= occ + 1'b1;
         else if (!accept && pop) occ <= occ - 1'b1;
      end
   end
endmodule

// File: rtl/fsf_readmux.sv
module fsf_readmux
   import fsf_pkg::*;
#(
   parameter int CNT_W  = 14,
   parameter int STAT_W = 8
) (
   input  logic [2:0]        addr,
   input  logic              en,
   input  logic              empty,
   input  logic              ovf,
   input  logic [CNT_W-1:0]  head_cnt,
   input  logic [STAT_W-1:0] head_stat,
   input  byte_t             live1,
   input  byte_t             img2,
   input  byte_t             img3,
   output byte_t             data
);
   logic [CNT_W-1:0]      cnt_v;
   logic [HI_FIELD_W-1:0] hi_v;
   byte_t                 stat_byte;

   generate
      if (STAT_W == 8) begin : g_full_stat
         assign stat_byte = byte_t'(head_stat);
      end else begin : g_merge_stat
         assign stat_byte = {live1[7:STAT_W], head_stat};
      end
   endgenerate

   always_comb begin
      cnt_v = empty ? '0 : head_cnt;
      hi_v  = '0;
      hi_v[CNT_W-9:0] = cnt_v[CNT_W-1:8];
   end

   always_comb begin
      case (addr)
         LOC_STAT:   data = (en && !empty) ? stat_byte : live1;
         LOC_IMG2:   data = img2;
         LOC_IMG3:   data = img3;
         LOC_CNT_LO: data = en ? cnt_v[7:0] : img2;
         LOC_CNT_HI: data = en ? {ovf, !empty, hi_v} : img3;
         default:    data = '0;
      endcase
   end
endmodule

// File: rtl/fsf_top.sv
module fsf_top
   import fsf_pkg::*;
#(
   parameter int DEPTH  = 10,
   parameter int CNT_W  = 14,
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              rx_sof,
   input  logic              rx_byte,
   input  logic              rx_eof,
   input  logic [STAT_W-1:0] rx_stat,
   input  logic              rd_en,
   input  logic [2:0]        rd_addr,
   input  logic [7:0]        live1_img,
   input  logic [7:0]        img2,
   input  logic [7:0]        img3,
   output logic [7:0]        rd_data
);
   localparam int EW = CNT_W + STAT_W;
   localparam int OW = $clog2(DEPTH + 1);

   generate
      if (CNT_W < 9 || CNT_W > 8 + HI_FIELD_W) begin : g_bad_cnt
         $error("fsf_top: CNT_W must lie in 9..14");
      end
      if (STAT_W < 1 || STAT_W > 8) begin : g_bad_stat
         $error("fsf_top: STAT_W must lie in 1..8");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("fsf_top: DEPTH must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_nx, cnt_q;
   logic [EW-1:0]    head;
   logic [OW-1:0]    occ;
   logic             empty, dropped, pop, push, ovf_q;

   fsf_bytecnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof      (rx_sof),
      .byte_stb (rx_byte),
      .cnt_nx   (cnt_nx),
      .cnt_q    (cnt_q)
   );

   assign pop  = rd_en && (rd_addr == LOC_STAT) && fifo_en && !empty;
   assign push = rx_eof && fifo_en;

   fsf_queue #(.DEPTH(DEPTH), .W(EW)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (!fifo_en),
      .push    (push),
      .pop     (pop),
      .din     ({rx_stat, cnt_nx}),
      .head    (head),
      .occ     (occ),
      .empty   (empty),
      .dropped (dropped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (!fifo_en) ovf_q <= 1'b0;
      else if (dropped) ovf_q <= 1'b1;
   end

   fsf_readmux #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_mux (
      .addr      (rd_addr),
      .en        (fifo_en),
      .empty     (empty),
      .ovf       (ovf_q),
      .head_cnt  (head[CNT_W-1:0]),
      .head_stat (head[EW-1:CNT_W]),
      .live1     (live1_img),
      .img2      (img2),
      .img3      (img3),
      .data      (rd_data)
   );
endmodule

// File: rtl/fsf_chk.sv
module fsf_chk
   import fsf_pkg::*;
#(
   parameter int DEPTH = 10,
   parameter int CNT_W = 14,
   localparam int OW   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_en,
   input logic             rx_sof,
   input logic             rx_byte,
   input logic             rx_eof,
   input logic             rd_en,
   input logic [2:0]       rd_addr,
   input logic [7:0]       rd_data,
   input logic [OW-1:0]    occ,
   input logic             ovf_q,
   input logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   // R1
   cnt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_byte && !rx_sof && cnt_q == CMAX) |=> (cnt_q == CMAX));

   // R2
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OW'(DEPTH));

   // R6
   peek_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && !rx_eof && !(rd_en && rd_addr == LOC_STAT)) |=> $stable(occ));

   // R7
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && rx_eof && occ == OW'(DEPTH) && !(rd_en && rd_addr == LOC_STAT))
      |=> (ovf_q && occ == OW'(DEPTH)));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && ovf_q) |=> ovf_q);

   // R8
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> (!ovf_q && occ == '0));

   // R10
   avail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && rd_addr == LOC_CNT_HI) |-> (rd_data[6] == (occ != '0)));
endmodule

bind fsf_top fsf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .fifo_en (fifo_en),
   .rx_sof  (rx_sof),
   .rx_byte (rx_byte),
   .rx_eof  (rx_eof),
   .rd_en   (rd_en),
   .rd_addr (rd_addr),
   .rd_data (rd_data),
   .occ     (occ),
   .ovf_q   (ovf_q),
   .cnt_q   (cnt_q)
);

// File: tb/sim_fsf_top.sv
`timescale 1ns/1ps
module sim_fsf_top;
   localparam int DEPTH  = 4;
   localparam int CNT_W  = 10;
   localparam int STAT_W = 4;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_en = 1'b0, rx_sof = 1'b0, rx_byte = 1'b0, rx_eof = 1'b0;
   logic [STAT_W-1:0] rx_stat = '0;
   logic rd_en = 1'b0;
   logic [2:0] rd_addr = '0;
   logic [7:0] live1_img = 8'hA5, img2 = 8'h3C, img3 = 8'hC3;
   logic [7:0] rd_data;

   int compared = 0, mismatched = 0;

   // reference model state
   int cnt_m = 0;
   bit ovf_m = 0;
   int qc[$];
   logic [STAT_W-1:0] qs[$];

   always #2 clk = ~clk;

   fsf_top #(.DEPTH(DEPTH), .CNT_W(CNT_W), .STAT_W(STAT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_sof(rx_sof),
      .rx_byte(rx_byte), .rx_eof(rx_eof), .rx_stat(rx_stat),
      .rd_en(rd_en), .rd_addr(rd_addr), .live1_img(live1_img),
      .img2(img2), .img3(img3), .rd_data(rd_data));

   function automatic logic [7:0] model_read(input logic [2:0] a, input bit en);
      bit emp;
      int c;
      emp = (qc.size() == 0);
      c   = emp ? 0 : qc[0];
      case (a)
         3'd1: model_read = (en && !emp) ? {live1_img[7:STAT_W], qs[0]} : live1_img;
         3'd2: model_read = img2;
         3'd3: model_read = img3;
         3'd6: model_read = en ? 8'(c & 255) : img2;
         3'd7: model_read = en ? {ovf_m, !emp, 6'(c >> 8)} : img3;
         default: model_read = 8'h00;
      endcase
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   // one clock: drive at negedge, compare before the edge, update model after it
   task automatic step(input bit s, input bit b, input bit e,
                       input logic [STAT_W-1:0] st, input bit en,
                       input bit rd, input logic [2:0] a, input string tag);
      logic [7:0] exp;
      int c;
      rx_sof = s; rx_byte = b; rx_eof = e; rx_stat = st;
      fifo_en = en; rd_en = rd; rd_addr = a;
      #1;
      exp = model_read(a, en);
      compared++;
      if (rd_data !== exp) begin
         mismatched++;
         $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rd_data, exp);
      end
      @(posedge clk);
      c = s ? 0 : cnt_m;
      if (b && c < CMAX) c++;
      cnt_m = c;
      if (!en) begin
         qc.delete(); qs.delete(); ovf_m = 0;
      end else begin
         if (rd && a == 3'd1 && qc.size() > 0) begin
            void'(qc.pop_front()); void'(qs.pop_front());
         end
         if (e) begin
            if (qc.size() < DEPTH) begin qc.push_back(c); qs.push_back(st); end
            else ovf_m = 1;
         end
      end
      @(negedge clk);
   endtask

   task automatic idle(input bit en, input logic [2:0] a, input string tag);
      step(0, 0, 0, '0, en, 0, a, tag);
   endtask

   task automatic strobe_rd(input logic [2:0] a, input string tag);
      step(0, 0, 0, '0, 1, 1, a, tag);
   endtask

   task automatic frame(input int n, input logic [STAT_W-1:0] st, input bit en,
                        input bit pop_last, input string tag);
      for (int k = 0; k < n; k++) begin
         bit last;
         last = (k == n - 1);
         step(k == 0, 1, last, st, en, last && pop_last,
              (last && pop_last) ? 3'd1 : 3'd7, tag);
      end
   endtask

   task automatic readout(input string tag);
      strobe_rd(3'd7, "R4");
      strobe_rd(3'd6, "R3");
      strobe_rd(3'd1, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      // reset state
      idle(1, 3'd7, "R10");
      idle(1, 3'd6, "R10");
      idle(1, 3'd1, "R5");
      // single-cycle frame, then several lengths
      frame(1, 4'h9, 1, 0, "R1");
      frame(3, 4'h5, 1, 0, "R2");
      frame(300, 4'hA, 1, 0, "R2");
      idle(1, 3'd1, "R5");
      idle(1, 3'd7, "R10");
      strobe_rd(3'd7, "R6");
      strobe_rd(3'd6, "R6");
      strobe_rd(3'd7, "R6");
      readout("R6");
      readout("R6");
      idle(1, 3'd6, "R3");
      readout("R6");
      // empty read at location 1 returns the live image
      live1_img = 8'h5E;
      strobe_rd(3'd1, "R5");
      idle(1, 3'd7, "R10");
      // overflow: five frames into four slots
      for (int i = 0; i < 5; i++) frame(2 + i, 4'(i + 1), 1, 0, "R7");
      idle(1, 3'd7, "R7");
      readout("R7");
      idle(1, 3'd7, "R7");
      // disabled: images, eof ignored, flag cleared
      img2 = 8'h81; img3 = 8'h18;
      idle(0, 3'd6, "R9");
      idle(0, 3'd7, "R9");
      idle(0, 3'd1, "R9");
      frame(4, 4'h7, 0, 0, "R8");
      idle(0, 3'd2, "R9");
      idle(0, 3'd3, "R9");
      idle(1, 3'd7, "R8");
      idle(1, 3'd1, "R8");
      // full queue with a coinciding removal and store
      for (int i = 0; i < 4; i++) frame(5 + i, 4'(8 + i), 1, 0, "R2");
      idle(1, 3'd7, "R11");
      frame(9, 4'hF, 1, 1, "R11");
      idle(1, 3'd7, "R11");
      for (int i = 0; i < 4; i++) readout("R11");
      idle(1, 3'd7, "R10");
      // counter ceiling
      frame(CMAX + 7, 4'h3, 1, 0, "R1");
      idle(1, 3'd6, "R1");
      idle(1, 3'd7, "R1");
      readout("R1");
      // unused locations
      idle(1, 3'd0, "R9");
      idle(1, 3'd4, "R9");
      idle(1, 3'd5, "R9");
      idle(1, 3'd2, "R9");
      idle(1, 3'd3, "R9");
      summary();
      $finish;
   end
endmodule